// File: doc/BRIEF.md
# Three-level longest-prefix route lookup ring

This block resolves 32-bit IPv4 destination addresses to 16-bit route values with a longest-prefix search over a table kept in an external memory. The search walks at most three table levels. The top 16 address bits index the first level. Each following level is indexed by a 19-bit pointer plus the next 8 address bits. A walk ends at the first leaf entry, so a lookup needs one, two or three memory reads.

The memory accepts one read per cycle and answers a fixed number of advancing cycles later. The block keeps one more slot register than that latency and chains them into a ring. Each occupied slot passes through the memory port once per lap. After its third lap it hands its result to the output stream and frees the slot for the next address. The slot schedule is fixed, so no arbitration is needed. A slot whose walk already ended at a leaf still makes its remaining laps, but it issues no reads on them.

Addresses arrive on a valid/ready stream and results leave on a valid/ready stream. An address is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when the slot leaving the ring is idle or is delivering its result. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole ring freezes: `out_valid` and `out_data` hold, and `mem_adv` drops so that the memory's response pipeline freezes as well. Results leave in the order their addresses arrived.

Top module: `lpm_ring_top`

## Requirements
- R1: After reset every slot is idle. `out_valid` and `mem_req` are 0, `mem_adv` is 1, and `in_ready` is 1.
- R2: In the cycle an address is accepted, `mem_req` is 1 and `mem_addr` equals address bits 31:16, zero-extended to 19 bits.
- R3: A table entry is 20 bits wide. When bit 19 is 1 the entry is a leaf and bits 15:0 are the result. A leaf at the first level gives that result with exactly one memory read.
- R4: When bit 19 is 0, bits 18:0 are a pointer. The next read address is that pointer plus the next unused 8 address bits (bits 15:8, then bits 7:0), computed as an arithmetic sum and not a concatenation.
- R5: With `out_ready` high, `out_valid` first rises exactly 3×(LATENCY+1) cycles after the accepting edge. That is 15 cycles for LATENCY=4.
- R6: A slot holding a finished result issues no further memory reads. The number of reads for a lookup equals the number of levels it walked.
- R7: `in_ready` is low while the slot leaving the ring needs another lap. It is high in the cycle a result is offered, so a new address can be taken in the same cycle a result leaves.
- R8: Up to LATENCY+1 lookups are in flight at once. Results leave in arrival order with the correct values.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. In that state `mem_adv`, `mem_req` and `in_ready` are 0, and lookups in flight finish correctly once `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | 32 | IPv4 address to look up |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 19 | Memory read address |
| mem_adv | output | 1 | Memory response pipeline advances this cycle |
| mem_rdata | input | 20 | Table entry returned LATENCY advancing cycles after its request |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | 16 | Route value |

## Verification
Two events can fall in the same cycle: a result leaving the ring and a new address entering the slot that result frees. The bench provokes this by holding `in_valid` high through a burst of six addresses. Five of them fill the ring, and the sixth must be accepted in the exact cycle the first result is offered. The ready pattern over those 16 cycles is compared cycle by cycle. Every result is then checked for value and arrival order. A second case overlaps emission with back-pressure: a read is still outstanding for a younger lookup when the stall begins, and that lookup must still resolve correctly.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int ENT_W  = 20;
  localparam int PTR_W  = ENT_W - 1;
  localparam int VAL_W  = 16;
  localparam int REST_W = ADDR_W - 16;
  localparam int STEP_W = 8;

  typedef enum logic [1:0] {LV_IDLE, LV_ONE, LV_TWO, LV_THREE} lvl_e;

  typedef struct packed {
    lvl_e               lvl;
    logic               done;
    logic [REST_W-1:0]  rest;
    logic [PTR_W-1:0]   ptr;
    logic [VAL_W-1:0]   val;
  } slot_t;

  function automatic lvl_e lvl_next(lvl_e l);
    case (l)
      LV_ONE:  return LV_TWO;
      LV_TWO:  return LV_THREE;
      default: return LV_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/lpm_resolve.sv
module lpm_resolve
  import lpm_pkg::*;
(
  input  slot_t             s_in,
  input  logic [ENT_W-1:0]  rdata,
  output slot_t             s_out
);
  logic live;
  assign live = (s_in.lvl != LV_IDLE) && !s_in.done;

  always_comb begin
    s_out = s_in;
    if (live) begin
      if (rdata[ENT_W-1]) begin
        s_out.done = 1'b1;
        s_out.val  = rdata[VAL_W-1:0];
      end else begin
        s_out.ptr  = rdata[PTR_W-1:0] + PTR_W'(s_in.rest[REST_W-1 -: STEP_W]);
        s_out.rest = s_in.rest << STEP_W;
      end
    end
  end
endmodule

// File: rtl/lpm_admit.sv
module lpm_admit
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             tail,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              in_ready,
  output slot_t             head,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr
);
  logic free;
  assign free     = (lvl_next(tail.lvl) == LV_IDLE);
  assign in_ready = adv && free;

  always_comb begin
    head     = '0;
    mem_req  = 1'b0;
    mem_addr = '0;
    if (free) begin
      if (in_valid && in_ready) begin
        head.lvl  = LV_ONE;
        head.rest = in_addr[REST_W-1:0];
        mem_req   = 1'b1;
        mem_addr  = PTR_W'(in_addr[ADDR_W-1:REST_W]);
      end
    end else begin
      head     = tail;
      head.lvl = lvl_next(tail.lvl);
      mem_req  = adv && !tail.done;
      mem_addr = tail.ptr;
    end
  end

  // R2
  accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (mem_req && mem_addr == PTR_W'(in_addr[ADDR_W-1:REST_W])));
  // R6
  done_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!free && tail.done) |-> !mem_req);
endmodule

// File: rtl/lpm_ring_top.sv
module lpm_ring_top
  import lpm_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_adv,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VAL_W-1:0]  out_data
);
  localparam int NSLOT = LATENCY + 1;
  localparam int LAST  = NSLOT - 1;

  slot_t ring [NSLOT];
  slot_t head, resolved;
  logic  stall, adv;

  assign out_valid = (ring[LAST].lvl == LV_THREE);
  assign out_data  = ring[LAST].val;
  assign stall     = out_valid && !out_ready;
  assign adv       = !stall;
  assign mem_adv   = adv;

  lpm_admit u_admit (
    .clk(clk), .rst_n(rst_n), .tail(ring[LAST]), .adv(adv),
    .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
    .head(head), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  lpm_resolve u_resolve (
    .s_in(ring[LAST-1]), .rdata(mem_rdata), .s_out(resolved)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   ring[0] <= '0;
    else if (adv) ring[0] <= head;
  end

  for (genvar k = 1; k < LAST; k++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rst_n)   ring[k] <= '0;
      else if (adv) ring[k] <= ring[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ring[LAST] <= '0;
    else if (adv) ring[LAST] <= resolved;
  end

  // R5
  result_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ring[LAST].done);
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!mem_req && !in_ready));
  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv) |-> (ring[1].lvl == $past(ring[0].lvl)));
endmodule

// File: tb/lpm_ring_top_bench.sv
`timescale 1ns/1ps
module lpm_ring_top_bench;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [31:0] in_addr = '0;
  logic        mem_req, mem_adv;
  logic [18:0] mem_addr;
  logic [19:0] mem_rdata;
  logic        out_valid, out_ready = 1;
  logic [15:0] out_data;

  int checks = 0, failures = 0, reqcnt = 0;
  logic [15:0] got [$];
  logic [18:0] mp [4];

  always #10 clk = ~clk;

  lpm_ring_top u_lpm_ring_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_adv(mem_adv), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [19:0] tbl(logic [18:0] a);
    if (a == 19'h00A0B) return {4'h8, 16'h1111};
    if (a == 19'h00C0D) return {1'b0, 19'h00100};
    if (a == 19'h00E0F) return {1'b0, 19'h001F0};
    if (a == 19'h00122) return {4'h8, 16'h2222};
    if (a == 19'h00133) return {1'b0, 19'h00200};
    if (a >= 19'h00200 && a < 19'h00300) return {4'h8, 8'h30, a[7:0]};
    return {4'h8, 16'hDEAD};
  endfunction

  function automatic logic [15:0] model(logic [31:0] ip, output int n);
    logic [19:0] p;
    p = tbl({3'b0, ip[31:16]}); n = 1;
    if (!p[19]) begin p = tbl(p[18:0] + 19'(ip[15:8])); n = 2; end
    if (!p[19]) begin p = tbl(p[18:0] + 19'(ip[7:0]));  n = 3; end
    return p[15:0];
  endfunction

  always @(posedge clk) if (mem_adv) begin
    mp[0] <= mem_addr;
    for (int i = 1; i < 4; i++) mp[i] <= mp[i-1];
  end
  assign mem_rdata = tbl(mp[3]);

  always @(posedge clk) begin
    if (mem_req) reqcnt <= reqcnt + 1;
    if (out_valid && out_ready) got.push_back(out_data);
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_got(int n);
    for (int i = 0; i < 200 && got.size() < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(in_ready == 1 && out_valid == 0 && mem_req == 0 && mem_adv == 1,
        "R1 reset", {in_ready, out_valid, mem_req, mem_adv}, 4'b1001);
  endtask

  task automatic t_single(logic [31:0] ip, string tag);
    int n, k;
    logic [15:0] e;
    e = model(ip, n);
    got.delete();
    @(negedge clk);
    reqcnt = 0;
    in_valid = 1; in_addr = ip; #1;
    chk(mem_req && mem_addr == {3'b0, ip[31:16]}, "R2 first read",
        mem_addr, ip[31:16]);
    @(posedge clk);
    @(negedge clk); in_valid = 0;
    k = 1;
    while (!out_valid && k < 40) begin @(negedge clk); k++; end
    chk(k == 15, "R5 latency", k, 15);
    chk(out_data == e, tag, out_data, e);
    @(negedge clk);
    chk(reqcnt == n, "R6 read count", reqcnt, n);
  endtask

  task automatic t_stream;
    logic [31:0] l [6] = '{32'h0A0B7788, 32'h0C0D2299, 32'h0C0D3345,
                           32'h0E0F2001, 32'h0C0D3300, 32'h12345678};
    logic rdy [16], ov [16];
    int idx = 0, n;
    got.delete();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      in_valid = (idx < 6); in_addr = l[idx < 6 ? idx : 5]; #1;
      rdy[c] = in_ready; ov[c] = out_valid;
      @(posedge clk);
      if (in_valid && rdy[c]) idx++;
    end
    @(negedge clk); in_valid = 0;
    for (int c = 0; c < 15; c++) begin
      logic e;
      e = (c < 5);
      chk(rdy[c] == e, "R7 ready pattern", rdy[c], e);
    end
    chk(rdy[15] && ov[15], "R7 emit and admit same cycle", {rdy[15], ov[15]}, 2'b11);
    wait_got(6);
    chk(got.size() == 6, "R8 result count", got.size(), 6);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] e;
      e = model(l[i], n);
      if (i < got.size()) chk(got[i] == e, "R8 order/value", got[i], e);
    end
  endtask

  task automatic t_stall;
    int r0, n;
    logic [15:0] e2;
    e2 = model(32'h0C0D3345, n);
    got.delete();
    out_ready = 0;
    @(negedge clk); in_valid = 1; in_addr = 32'h0A0B7788;
    @(negedge clk); in_valid = 0;
    @(negedge clk); in_valid = 1; in_addr = 32'h0C0D3345;
    @(negedge clk); in_valid = 0;
    for (int i = 0; i < 40 && !out_valid; i++) @(negedge clk);
    in_valid = 1; in_addr = 32'h12345678;
    r0 = reqcnt;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(out_valid && out_data == 16'h1111, "R9 hold", out_data, 16'h1111);
      chk(!mem_adv && !mem_req && !in_ready, "R9 frozen",
          {mem_adv, mem_req, in_ready}, 0);
      @(negedge clk);
    end
    chk(reqcnt == r0 && got.size() == 0, "R9 no traffic", reqcnt - r0, 0);
    in_valid = 0; out_ready = 1;
    wait_got(2);
    chk(got.size() == 2 && got[0] == 16'h1111, "R9 first after release",
        got.size() > 0 ? got[0] : 0, 16'h1111);
    chk(got.size() == 2 && got[1] == e2, "R9 in-flight survives",
        got.size() > 1 ? got[1] : 0, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single(32'h0A0B7788, "R3 level-one leaf");
    t_single(32'h0C0D2299, "R4 two-level");
    t_single(32'h0C0D3345, "R4 three-level");
    t_single(32'h0E0F2001, "R4 pointer sum carry");
    t_single(32'h12345678, "R3 default leaf");
    t_stream();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule